// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block drives the control points of a multi-cycle processor datapath from a small microcode store. Each cycle the current micro-address selects one word from the store. The word carries the datapath control bits plus a 2-bit sequencing field. The outputs depend only on the current micro-address, so the block behaves as a Moore machine.

The next micro-address is not held in the store. Separate select logic chooses it from four sources, steered by the sequencing field:

- the fetch address (zero);
- a first opcode-indexed jump table, used after decode;
- a second opcode-indexed jump table, used after address computation;
- the current address plus one.

The store and both tables are fixed constants. The enclosing datapath supplies the opcode of the held instruction and keeps it stable from the decode cycle to the end of the instruction.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the micro-address becomes 0 (fetch), and the outputs show the fetch word in the following cycle.
- R2: The fetch word drives the following outputs: `mem_rd`=1, `instr_load`=1, `pc_load`=1, `alu_b_sel`=01, `alu_a_sel`=0, `alu_mode`=00, `pc_next_sel`=00, `addr_from_alu`=0. All other outputs are 0.
- R3: Fetch is always followed by decode. The decode word sets `alu_b_sel`=11, `alu_a_sel`=0 and `alu_mode`=00, and all other outputs are 0.
- R4: A load (opcode 6'h23) runs 5 cycles: fetch, decode, address compute, memory read, write-back.
  - Address compute: `alu_a_sel`=1, `alu_b_sel`=10.
  - Memory read: `mem_rd`=1, `addr_from_alu`=1.
  - Write-back: `rf_write`=1, `wb_from_mem`=1, `rf_dest_rd`=0.
- R5: A store (opcode 6'h2B) runs 4 cycles: fetch, decode, address compute, then a memory write cycle with `mem_wr`=1 and `addr_from_alu`=1.
- R6: An R-type instruction (opcode 6'h00) runs 4 cycles: fetch, decode, execute, completion.
  - Execute: `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=10.
  - Completion: `rf_write`=1, `rf_dest_rd`=1, `wb_from_mem`=0.
- R7: A branch-equal (opcode 6'h04) runs 3 cycles. Its last cycle sets `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_load_if_eq`=1 and `pc_next_sel`=01.
- R8: A jump (opcode 6'h02) runs 3 cycles. Its last cycle sets `pc_load`=1 and `pc_next_sel`=10.
- R9: Any other opcode returns to fetch directly after decode.
- R10: The opcode is ignored in every cycle except decode and address compute. Changing it in any other cycle has no effect on the outputs or on the sequence.
- R11: `mem_rd` and `mem_wr` are never high together, and neither are `pc_load` and `pc_load_if_eq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode of the held instruction |
| pc_load | output | 1 | Unconditional program counter load |
| pc_load_if_eq | output | 1 | Program counter load when the ALU reports equality |
| addr_from_alu | output | 1 | Memory address from the ALU result register (1) or the PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| instr_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from the memory data register |
| pc_next_sel | output | 2 | Next PC: 00 incremented, 01 branch target, 10 jump target |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 by function field |
| alu_b_sel | output | 2 | ALU B: 00 register B, 01 constant 4, 10 offset, 11 offset times 4 |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| rf_write | output | 1 | Register file write |
| rf_dest_rd | output | 1 | Destination from the rd field (1) or the rt field (0) |

## Verification
Each of the five supported opcodes is run through its full path, one cycle at a time. The outputs are compared against an independent model of the equivalent hardwired state machine, and the cycle count is checked. This separates the two jump tables and the sequential advance.

Several unsupported opcodes show that the first table falls back to fetch. Runs that scramble the opcode outside the two dispatch cycles show that only those cycles consult it. A reset in the middle of a load and back-to-back mixed instructions show that the return to fetch is clean.

// File: rtl/mc_pkg.sv
// Package: shared widths, opcode encodings and the control word layout
// for the microprogrammed sequencer. Assumes the 6-bit opcode encoding
// listed in the requirements.
package mc_pkg;
    parameter int OPC_W = 6;
    parameter int NUM_UADDR = 10;
    localparam int UA_W = $clog2(NUM_UADDR);
    localparam int SEQ_W = 2;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    // Micro-addresses
    localparam logic [UA_W-1:0] UA_FETCH = 4'd0;
    localparam logic [UA_W-1:0] UA_DECODE = 4'd1;
    localparam logic [UA_W-1:0] UA_MADDR = 4'd2;
    localparam logic [UA_W-1:0] UA_MREAD = 4'd3;
    localparam logic [UA_W-1:0] UA_LDWB = 4'd4;
    localparam logic [UA_W-1:0] UA_STWR = 4'd5;
    localparam logic [UA_W-1:0] UA_EXEC = 4'd6;
    localparam logic [UA_W-1:0] UA_RWB = 4'd7;
    localparam logic [UA_W-1:0] UA_BRANCH = 4'd8;
    localparam logic [UA_W-1:0] UA_JUMP = 4'd9;

    // Sequencing field encodings
    typedef enum logic [SEQ_W-1:0] {
        SEQ_FETCH = 2'd0,
        SEQ_TBL1  = 2'd1,
        SEQ_TBL2  = 2'd2,
        SEQ_NEXT  = 2'd3
    } seq_ctl_e;

    typedef struct packed {
        logic       pc_load;
        logic       pc_load_if_eq;
        logic       addr_from_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_load;
        logic       wb_from_mem;
        logic [1:0] pc_next_sel;
        logic [1:0] alu_mode;
        logic [1:0] alu_b_sel;
        logic       alu_a_sel;
        logic       rf_write;
        logic       rf_dest_rd;
    } ctrl_t;

    typedef struct packed {
        ctrl_t    ctrl;
        seq_ctl_e seq;
    } uword_t;
endpackage

// File: rtl/mc_ustore.sv
// Microcode store: maps a micro-address to its microword.
// Assumes unused addresses hold an all-zero word that returns to fetch.
module mc_ustore
    import mc_pkg::*;
(
    input  logic [UA_W-1:0] uaddr,
    output uword_t          word
);
    // Constant store contents, one microword per address
    always_comb begin
        word = '0;
        word.seq = SEQ_FETCH;
        case (uaddr)
            UA_FETCH: begin
                word.ctrl.mem_rd     = 1'b1;
                word.ctrl.instr_load = 1'b1;
                word.ctrl.pc_load    = 1'b1;
                word.ctrl.alu_b_sel  = 2'b01;
                word.seq             = SEQ_NEXT;
            end
            UA_DECODE: begin
                word.ctrl.alu_b_sel = 2'b11;
                word.seq            = SEQ_TBL1;
            end
            UA_MADDR: begin
                word.ctrl.alu_a_sel = 1'b1;
                word.ctrl.alu_b_sel = 2'b10;
                word.seq            = SEQ_TBL2;
            end
            UA_MREAD: begin
                word.ctrl.mem_rd        = 1'b1;
                word.ctrl.addr_from_alu = 1'b1;
                word.seq                = SEQ_NEXT;
            end
            UA_LDWB: begin
                word.ctrl.rf_write    = 1'b1;
                word.ctrl.wb_from_mem = 1'b1;
            end
            UA_STWR: begin
                word.ctrl.mem_wr        = 1'b1;
                word.ctrl.addr_from_alu = 1'b1;
            end
            UA_EXEC: begin
                word.ctrl.alu_a_sel = 1'b1;
                word.ctrl.alu_mode  = 2'b10;
                word.seq            = SEQ_NEXT;
            end
            UA_RWB: begin
                word.ctrl.rf_write   = 1'b1;
                word.ctrl.rf_dest_rd = 1'b1;
            end
            UA_BRANCH: begin
                word.ctrl.alu_a_sel     = 1'b1;
                word.ctrl.alu_mode      = 2'b01;
                word.ctrl.pc_load_if_eq = 1'b1;
                word.ctrl.pc_next_sel   = 2'b01;
            end
            UA_JUMP: begin
                word.ctrl.pc_load     = 1'b1;
                word.ctrl.pc_next_sel = 2'b10;
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/mc_jump_table.sv
// Opcode-indexed jump table. TABLE picks the variant:
//   1 = after-decode table,
//   2 = after-address-compute table.
// Assumes opcodes that are absent from a table map to fetch.
module mc_jump_table
    import mc_pkg::*;
#(
    parameter int TABLE = 1
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  target
);
    generate
        if (TABLE == 1) begin : g_decode_tbl
            // Route each instruction class to its first execution step
            always_comb begin
                case (opcode)
                    OP_RTYPE: target = UA_EXEC;
                    OP_JUMP:  target = UA_JUMP;
                    OP_BEQ:   target = UA_BRANCH;
                    OP_LOAD,
                    OP_STORE: target = UA_MADDR;
                    default:  target = UA_FETCH;
                endcase
            end
        end else begin : g_mem_tbl
            // Split memory instructions into read or write paths
            always_comb begin
                case (opcode)
                    OP_LOAD:  target = UA_MREAD;
                    OP_STORE: target = UA_STWR;
                    default:  target = UA_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/mc_addr_sel.sv
// Next micro-address select: a four-way choice of fetch, table 1,
// table 2 or the incremented address, steered by the sequencing field.
// Assumes the store never asks to advance past its last word.
module mc_addr_sel
    import mc_pkg::*;
(
    input  seq_ctl_e        seq,
    input  logic [UA_W-1:0] cur,
    input  logic [UA_W-1:0] tbl1,
    input  logic [UA_W-1:0] tbl2,
    output logic [UA_W-1:0] nxt
);
    logic [UA_W-1:0] inc;

    // Sequential successor of the current address
    assign inc = cur + 1'b1;

    // Four-way next-address choice
    always_comb begin
        case (seq)
            SEQ_TBL1: nxt = tbl1;
            SEQ_TBL2: nxt = tbl2;
            SEQ_NEXT: nxt = inc;
            default:  nxt = UA_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_sequencer.sv
// Top: microprogrammed control sequencer. Holds the micro-address
// register and drives the datapath controls from the store word.
// Assumes opcode is stable from decode to the end of the instruction.
module mc_sequencer
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_load,
    output logic             pc_load_if_eq,
    output logic             addr_from_alu,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             instr_load,
    output logic             wb_from_mem,
    output logic [1:0]       pc_next_sel,
    output logic [1:0]       alu_mode,
    output logic [1:0]       alu_b_sel,
    output logic             alu_a_sel,
    output logic             rf_write,
    output logic             rf_dest_rd
);
    logic [UA_W-1:0] uaddr;
    logic [UA_W-1:0] uaddr_nxt;
    logic [UA_W-1:0] tbl1_tgt;
    logic [UA_W-1:0] tbl2_tgt;
    uword_t          word;

    mc_ustore u_store (
        .uaddr (uaddr),
        .word  (word)
    );

    mc_jump_table #(.TABLE(1)) u_tbl1 (
        .opcode (opcode),
        .target (tbl1_tgt)
    );

    mc_jump_table #(.TABLE(2)) u_tbl2 (
        .opcode (opcode),
        .target (tbl2_tgt)
    );

    mc_addr_sel u_sel (
        .seq  (word.seq),
        .cur  (uaddr),
        .tbl1 (tbl1_tgt),
        .tbl2 (tbl2_tgt),
        .nxt  (uaddr_nxt)
    );

    // Micro-address register with synchronous reset to fetch
    always_ff @(posedge clk) begin
        if (!rst_n) uaddr <= UA_FETCH;
        else        uaddr <= uaddr_nxt;
    end

    // Unpack the control bits onto the ports
    assign pc_load       = word.ctrl.pc_load;
    assign pc_load_if_eq = word.ctrl.pc_load_if_eq;
    assign addr_from_alu = word.ctrl.addr_from_alu;
    assign mem_rd        = word.ctrl.mem_rd;
    assign mem_wr        = word.ctrl.mem_wr;
    assign instr_load    = word.ctrl.instr_load;
    assign wb_from_mem   = word.ctrl.wb_from_mem;
    assign pc_next_sel   = word.ctrl.pc_next_sel;
    assign alu_mode      = word.ctrl.alu_mode;
    assign alu_b_sel     = word.ctrl.alu_b_sel;
    assign alu_a_sel     = word.ctrl.alu_a_sel;
    assign rf_write      = word.ctrl.rf_write;
    assign rf_dest_rd    = word.ctrl.rf_dest_rd;
endmodule

// File: rtl/mc_sequencer_chk.sv
// Checker for mc_sequencer: port-level sequencing properties.
// Fetch is recognised by instr_load, decode by alu_b_sel==11.
module mc_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] opcode,
    input logic       pc_load,
    input logic       pc_load_if_eq,
    input logic       addr_from_alu,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       instr_load,
    input logic       wb_from_mem,
    input logic [1:0] pc_next_sel,
    input logic [1:0] alu_mode,
    input logic [1:0] alu_b_sel,
    input logic       alu_a_sel,
    input logic       rf_write,
    input logic       rf_dest_rd
);
    logic is_decode;
    logic is_fetch;
    logic op_known;

    assign is_decode = (alu_b_sel == 2'b11);
    assign is_fetch  = instr_load && pc_load && mem_rd;
    assign op_known  = (opcode == 6'h00) || (opcode == 6'h02)
                    || (opcode == 6'h04) || (opcode == 6'h23)
                    || (opcode == 6'h2B);

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        !rst_n |=> is_fetch);

    // R3
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_fetch |=> is_decode);

    // R4
    load_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_from_alu) |=> (rf_write && wb_from_mem && !rf_dest_rd));

    // R6
    rtype_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode == 2'b10) |=> (rf_write && rf_dest_rd && !wb_from_mem));

    // R7
    branch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode == 2'b01) |-> (pc_load_if_eq && !pc_load && pc_next_sel == 2'b01));

    // R8
    jump_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_next_sel == 2'b10) |=> is_fetch);

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_decode && !op_known) |=> is_fetch);

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_load && pc_load_if_eq));
endmodule

bind mc_sequencer mc_sequencer_chk u_chk (.*);

// File: tb/test_mc_sequencer.sv
`timescale 1ns/1ps
// Directed bench: per-cycle comparison against a hardwired reference model.
module test_mc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       pc_load, pc_load_if_eq, addr_from_alu, mem_rd, mem_wr;
    logic       instr_load, wb_from_mem, alu_a_sel, rf_write, rf_dest_rd;
    logic [1:0] pc_next_sel, alu_mode, alu_b_sel;
    logic [15:0] got;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mc_sequencer i_mc_sequencer (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq),
        .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .instr_load(instr_load), .wb_from_mem(wb_from_mem),
        .pc_next_sel(pc_next_sel), .alu_mode(alu_mode), .alu_b_sel(alu_b_sel),
        .alu_a_sel(alu_a_sel), .rf_write(rf_write), .rf_dest_rd(rf_dest_rd)
    );

    assign got = {pc_load, pc_load_if_eq, addr_from_alu, mem_rd, mem_wr,
                  instr_load, wb_from_mem, pc_next_sel, alu_mode, alu_b_sel,
                  alu_a_sel, rf_write, rf_dest_rd};

    // Expected outputs per step of the hardwired reference machine
    function automatic logic [15:0] exp_ctrl(input int st);
        logic pl = 0, pe = 0, ad = 0, rd = 0, wr = 0, il = 0, wm = 0;
        logic as = 0, rw = 0, dr = 0;
        logic [1:0] ps = 0, am = 0, bs = 0;
        case (st)
            0: begin rd = 1; il = 1; pl = 1; bs = 2'b01; end
            1: bs = 2'b11;
            2: begin as = 1; bs = 2'b10; end
            3: begin rd = 1; ad = 1; end
            4: begin rw = 1; wm = 1; end
            5: begin wr = 1; ad = 1; end
            6: begin as = 1; am = 2'b10; end
            7: begin rw = 1; dr = 1; end
            8: begin as = 1; am = 2'b01; pe = 1; ps = 2'b01; end
            9: begin pl = 1; ps = 2'b10; end
            default: ;
        endcase
        return {pl, pe, ad, rd, wr, il, wm, ps, am, bs, as, rw, dr};
    endfunction

    // Reference next step of the hardwired machine
    function automatic int ref_next(input int st, input logic [5:0] op);
        case (st)
            0: return 1;
            1: case (op)
                   6'h00: return 6;
                   6'h02: return 9;
                   6'h04: return 8;
                   6'h23, 6'h2B: return 2;
                   default: return 0;
               endcase
            2: return (op == 6'h23) ? 3 : ((op == 6'h2B) ? 5 : 0);
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
        checks++;
        if ((mem_rd && mem_wr) || (pc_load && pc_load_if_eq)) begin
            errors++;
            $display("FAIL R11: got %h expected no conflicting strobes", got);
        end
    endtask

    // Entry: negedge in fetch. Exit: negedge in the next fetch.
    task automatic run_instr(input logic [5:0] op, input int exp_len,
                             input bit scramble, input string req);
        int st;
        int nx;
        int n;
        st = 0;
        n = 0;
        do begin
            if (scramble && st != 1 && st != 2) opcode = ~op ^ 6'(n * 7);
            else opcode = op;
            #1;
            check(req, exp_ctrl(st));
            n++;
            nx = ref_next(st, op);
            @(negedge clk);
            st = nx;
        end while (st != 0 && n < 10);
        checks++;
        if (n != exp_len) begin
            errors++;
            $display("FAIL %s: got length %0d expected %0d", req, n, exp_len);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R1", exp_ctrl(0));
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1", exp_ctrl(0));
        #1 check("R2", exp_ctrl(0));
    endtask

    task automatic t_load;      run_instr(6'h23, 5, 1'b0, "R4"); endtask
    task automatic t_store;     run_instr(6'h2B, 4, 1'b0, "R5"); endtask
    task automatic t_rtype;     run_instr(6'h00, 4, 1'b0, "R6"); endtask
    task automatic t_branch;    run_instr(6'h04, 3, 1'b0, "R7"); endtask
    task automatic t_jump;      run_instr(6'h02, 3, 1'b0, "R8"); endtask

    task automatic t_unknown;
        run_instr(6'h01, 2, 1'b0, "R9");
        run_instr(6'h3F, 2, 1'b0, "R9");
        run_instr(6'h22, 2, 1'b0, "R9");
        run_instr(6'h2A, 2, 1'b0, "R9");
    endtask

    task automatic t_ignore;
        run_instr(6'h23, 5, 1'b1, "R10");
        run_instr(6'h2B, 4, 1'b1, "R10");
        run_instr(6'h00, 4, 1'b1, "R10");
        run_instr(6'h04, 3, 1'b1, "R10");
    endtask

    task automatic t_mid_reset;
        opcode = 6'h23;
        repeat (3) @(negedge clk);
        #1 check("R4", exp_ctrl(3));
        rst_n = 1'b0;
        @(negedge clk);
        #1 check("R1", exp_ctrl(0));
        rst_n = 1'b1;
        run_instr(6'h23, 5, 1'b0, "R1");
    endtask

    task automatic t_mix;
        run_instr(6'h02, 3, 1'b0, "R3");
        run_instr(6'h23, 5, 1'b0, "R3");
        run_instr(6'h04, 3, 1'b0, "R3");
        run_instr(6'h2B, 4, 1'b0, "R3");
        run_instr(6'h00, 4, 1'b0, "R3");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_store();
        t_rtype();
        t_branch();
        t_jump();
        t_unknown();
        t_ignore();
        t_mid_reset();
        t_mix();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule